// File: doc/BRIEF.md
# Automatic Stop-Command Response Checker

This block sits beside the command path of an SD-style host controller and judges the response to the stop command that the host sends by itself once a multi-block memory transfer has to be ended. When the host asks for the stop, the block clears its previous verdict. It then waits for the strobe that marks the end of the transmitted command and watches the serial command line for the start of the 48-bit response. Each bit is taken on a rising card-clock edge. The response is checked for a missing start, a wrong command index, a bad CRC7 and a bad end bit.

The verdict is a 32-bit read-only status word plus a one-cycle summary error strobe. The word holds its value until the next stop request and is meaningful only once the strobe has fired. Two flags take precedence over the rest. A stop that could not be issued at all sets the not-executed flag. A response that never starts sets the timeout flag. In both cases the response-content flags stay clear. A separate flag records that a queued command without a data phase was held back because the stop ended in error. When the data transfer never started, no stop is needed and no flag is raised.

Top module: `stop_resp_checker`

## Requirements
- R1: A cycle with `stop_req` high clears every status bit, so `status` reads 0 on the following cycle unless R3 applies. After reset `status` is 0 and `err_o` is 0.
- R2: A `stop_req` with `xfer_started` low raises no flag. Any later `cmd_end` and response bits are ignored: `status` stays 0 and `err_o` stays 0.
- R3: A `stop_req` with `xfer_started` and `issue_err` both high sets the not-executed flag `status[0]` on the next cycle and pulses `err_o`. Bits 4..1 stay 0.
- R4: After the `cmd_end` cycle, the first 0 on `cmd_in` within the next 64 clock cycles is taken as the response start bit. If no 0 is seen in those 64 cycles, the timeout flag `status[1]` is set on the 64th cycle. Bits 4..2 stay 0 and further line activity is ignored.
- R5: The response is 48 bits, MSB first: start bit, transmission bit, 6-bit index, 32-bit argument, 7-bit CRC, end bit. An index other than 12 sets `status[4]`.
- R6: A 7-bit CRC field that differs from the CRC7 (polynomial x^7+x^3+1, zero seed) of the first 40 response bits sets `status[3]`.
- R7: A final response bit of 0 sets `status[2]`.
- R8: `status[7]` (queued command not issued) is set together with any error flag when `queued_cmd` is high at that update. It is never set without an error flag.
- R9: `err_o` is high for exactly one cycle, and only when the completing update (R3, R4 or the final response bit) set at least one error flag. A clean response leaves `status` at 0 with no strobe. All bits other than 7 and 4..0 read 0.
- R10: The status bits keep their value until the next `stop_req`. Counting bit 0 as the MSB, as in the host's register numbering, bits 7,4,3,2,1,0 here are word bits 24,27,28,29,30,31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to issue the automatic stop |
| xfer_started | input | 1 | Multi-block data transfer actually started (sampled with `stop_req`) |
| issue_err | input | 1 | Stop command cannot be issued because of an error (sampled with `stop_req`) |
| cmd_end | input | 1 | Strobe in the cycle of the stop command's end bit |
| queued_cmd | input | 1 | A non-data command is waiting behind the stop |
| cmd_in | input | 1 | Serial command-line response bit |
| status | output | 32 | Error status word (layout in R3-R10) |
| err_o | output | 1 | One-cycle summary error strobe |

## Verification
The three response-content checks finish in the same final-bit cycle. One directed response therefore carries a wrong index, an inverted CRC bit and a zero end bit, with a non-data command queued. The bench expects index, CRC, end-bit and command-not-issued flags all raised in that single update, under a single `err_o` pulse. The timeout boundary is provoked by starting the response on the 64th and then on the 65th waiting cycle. In the timed-out case, a well-formed response that arrives afterwards must leave the word untouched.

// File: rtl/stop_resp_checker.sv
module stop_resp_checker #(
  parameter int          TMO_CYC  = 64,
  parameter int          RSP_LEN  = 48,
  parameter int          CRC_SPAN = 40,
  parameter logic [5:0]  STOP_IDX = 6'd12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_req,
  input  logic        xfer_started,
  input  logic        issue_err,
  input  logic        cmd_end,
  input  logic        queued_cmd,
  input  logic        cmd_in,
  output logic [31:0] status,
  output logic        err_o
);
  localparam int CW     = $clog2(TMO_CYC + 1);
  localparam int BW     = $clog2(RSP_LEN);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + 5;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_WAIT, S_RECV} st_t;
  st_t st;

  logic [CW-1:0] wcnt;
  logic [BW-1:0] bcnt;
  logic [6:0]    crc, tail;
  logic [5:0]    idx;
  logic          f_cni, f_idx, f_crc, f_end, f_tmo, f_nex;

  wire [6:0] crc_nxt = {crc[5:0], 1'b0} ^ ({7{cmd_in ^ crc[6]}} & 7'h09);
  wire       idx_bad = idx != STOP_IDX;
  wire       crc_bad = tail != crc;
  wire       end_bad = !cmd_in;
  wire       any_bad = idx_bad | crc_bad | end_bad;

  assign status = {24'b0, f_cni, 2'b00, f_idx, f_crc, f_end, f_tmo, f_nex};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wcnt  <= '0;
      bcnt  <= '0;
      crc   <= '0;
      tail  <= '0;
      idx   <= '0;
      {f_cni, f_idx, f_crc, f_end, f_tmo, f_nex} <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (stop_req) begin
        {f_cni, f_idx, f_crc, f_end, f_tmo, f_nex} <= '0;
        if (xfer_started && issue_err) begin
          f_nex <= 1'b1;
          f_cni <= queued_cmd;
          err_o <= 1'b1;
          st    <= S_IDLE;
        end else begin
          st <= xfer_started ? S_ARM : S_IDLE;
        end
      end else begin
        case (st)
          S_ARM: if (cmd_end) begin
            st   <= S_WAIT;
            wcnt <= '0;
          end
          S_WAIT: begin
            if (!cmd_in) begin
              st   <= S_RECV;
              bcnt <= BW'(1);
              crc  <= '0;
            end else if (wcnt == CW'(TMO_CYC - 1)) begin
              f_tmo <= 1'b1;
              f_cni <= queued_cmd;
              err_o <= 1'b1;
              st    <= S_IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_RECV: begin
            tail <= {tail[5:0], cmd_in};
            if (bcnt < BW'(CRC_SPAN))
              crc <= crc_nxt;
            if (bcnt >= BW'(IDX_LO) && bcnt <= BW'(IDX_HI))
              idx <= {idx[4:0], cmd_in};
            if (bcnt == BW'(RSP_LEN - 1)) begin
              f_idx <= idx_bad;
              f_crc <= crc_bad;
              f_end <= end_bad;
              f_cni <= queued_cmd & any_bad;
              err_o <= any_bad;
              st    <= S_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/stop_resp_checker_sva.sv
module stop_resp_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        stop_req,
  input logic        xfer_started,
  input logic        issue_err,
  input logic [31:0] status,
  input logic        err_o
);
  a_r1_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !(xfer_started && issue_err)) |=> (status == 32'h0 && !err_o));

  a_r2_no_stop_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !xfer_started) |=> (status == 32'h0));

  a_r3_not_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && xfer_started && issue_err) |=> (status[0] && status[4:1] == 4'h0 && err_o));

  a_r4_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (status[4:2] == 3'h0 && !status[0]));

  a_r8_cni_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> (status[4:0] != 5'h0));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  a_r9_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (status[4:0] != 5'h0));

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:8] == 24'h0 && status[6:5] == 2'h0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stop_req) && $past(status[4:0]) != 5'h0) |-> $stable(status));
endmodule

bind stop_resp_checker stop_resp_checker_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_req     (stop_req),
  .xfer_started (xfer_started),
  .issue_err    (issue_err),
  .status       (status),
  .err_o        (err_o)
);

// File: tb/test_stop_resp_checker.sv
module test_stop_resp_checker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 0, xfer_started = 0, issue_err = 0, cmd_end = 0, queued_cmd = 0, cmd_in = 1;
  logic [31:0] status;
  logic err_o;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stop_resp_checker i_stop_resp_checker (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .xfer_started(xfer_started),
    .issue_err(issue_err), .cmd_end(cmd_end), .queued_cmd(queued_cmd),
    .cmd_in(cmd_in), .status(status), .err_o(err_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] frame(input logic [5:0] ix, input logic [31:0] arg,
                                        input bit bad_crc, input logic eb);
    logic [39:0] h = {2'b00, ix, arg};
    logic [6:0]  c = crc7(h) ^ {6'b0, bad_crc};
    return {h, c, eb};
  endfunction

  task automatic send_stop(input logic xs, input logic ie, input logic q);
    @(negedge clk);
    stop_req = 1; xfer_started = xs; issue_err = ie; queued_cmd = q;
    @(negedge clk);
    stop_req = 0; issue_err = 0;
  endtask

  // caller sits on the negedge after send_stop; returns on the negedge after the final edge
  task automatic send_resp(input int d, input logic [47:0] f, output bit saw_err);
    saw_err = 0;
    cmd_end = 1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk); cmd_end = 0; cmd_in = 1; saw_err |= err_o;
    end
    for (int b = 47; b >= 0; b--) begin
      @(negedge clk); cmd_end = 0; cmd_in = f[b]; saw_err |= err_o;
    end
    @(negedge clk); cmd_in = 1;
  endtask

  task automatic t_reset;
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset err_o", {31'b0, err_o}, 32'h0);
  endtask

  task automatic t_resp(input string req, input logic [5:0] ix, input bit bad_crc,
                        input logic eb, input logic q, input int d, input logic [31:0] exp);
    bit s;
    send_stop(1, 0, q);
    chk({req, " cleared"}, status, 32'h0);
    send_resp(d, frame(ix, 32'hA5C3_0F1E ^ 32'(d), bad_crc, eb), s);
    chk({req, " no early strobe"}, {31'b0, s}, 32'h0);
    chk({req, " status"}, status, exp);
    chk({req, " R9 strobe"}, {31'b0, err_o}, {31'b0, exp != 0});
    @(negedge clk);
    chk({req, " R9 strobe one cycle"}, {31'b0, err_o}, 32'h0);
    chk({req, " R10 held"}, status, exp);
  endtask

  task automatic t_timeout(input logic q);
    bit s;
    send_stop(1, 0, q);
    cmd_end = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); cmd_end = 0; cmd_in = 1;
    end
    @(negedge clk);
    chk("R4 timeout status", status, q ? 32'h82 : 32'h02);
    chk("R9 timeout strobe", {31'b0, err_o}, 32'h1);
    s = 0;
    for (int b = 47; b >= 0; b--) begin
      cmd_in = frame(6'd13, 32'h0, 1, 0) >> b;
      @(negedge clk); s |= err_o;
    end
    cmd_in = 1;
    chk("R4 late response ignored", status, q ? 32'h82 : 32'h02);
    chk("R4 no strobe after timeout", {31'b0, s}, 32'h0);
  endtask

  task automatic t_not_exec;
    send_stop(1, 1, 0);
    chk("R3 not-executed status", status, 32'h01);
    chk("R3 not-executed strobe", {31'b0, err_o}, 32'h1);
    @(negedge clk);
    chk("R9 not-executed strobe one cycle", {31'b0, err_o}, 32'h0);
  endtask

  task automatic t_no_xfer;
    bit s;
    send_stop(1, 0, 1);
    send_stop(0, 1, 1);
    chk("R2 no-transfer cleared", status, 32'h0);
    send_resp(3, frame(6'd5, 32'h1234, 1, 0), s);
    chk("R2 no-transfer status", status, 32'h0);
    chk("R2 no-transfer strobe", {31'b0, s | err_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_resp("R9 good response", 6'd12, 0, 1, 1, 5, 32'h00);
    t_resp("R5 index error", 6'd13, 0, 1, 0, 2, 32'h10);
    t_resp("R6 crc error", 6'd12, 1, 1, 0, 0, 32'h08);
    t_resp("R7 end-bit error", 6'd12, 0, 0, 0, 7, 32'h04);
    t_resp("R8 all content errors queued", 6'd44, 1, 0, 1, 1, 32'h9C);
    t_resp("R4 start on 64th cycle", 6'd12, 0, 1, 1, 63, 32'h00);
    t_timeout(1);
    t_timeout(0);
    t_not_exec();
    t_resp("R1 clear after error", 6'd12, 0, 1, 0, 4, 32'h00);
    t_no_xfer();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule